// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Selector

This block takes two encoded IEEE-754 binary floating-point operands of the same precision and returns either the greater or the lesser of them. A per-beat precision bit selects single (32-bit) or double (64-bit) layout, and a per-beat operation bit selects maximum or minimum. Alongside the result it reports two exception flags. One is raised when a signaling NaN was consumed. The other is raised when both operands were infinities of the same sign.

Decisions follow a fixed priority. The chain checks for a signaling NaN on the left operand and then on the right. It then checks for a quiet NaN on the left and then on the right. Next it checks for infinity on the left and then on the right. Only after all of these does it order the operands, first by sign and then by magnitude. For finite values the magnitude is compared as the unsigned concatenation of exponent and fraction. This orders zeros, denormals and normals without normalising them.

Operands enter through a valid/ready port and the result leaves through a second valid/ready port, one register stage later. A beat is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its result and flags appear on the output on the following cycle and remain there until they are taken. A result is taken on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. Back-pressure on the output therefore stalls the input with no loss and no duplication.

Top module: `fp_minmax`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1. An accepted beat drives `out_valid` high on the next cycle. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready` holds, the result and flags hold steady and no new beat is accepted.
- R2: A signaling NaN is a NaN whose quiet bit is clear. The quiet bit is fraction bit 22 in single precision and bit 51 in double precision. When an operand is a signaling NaN, the result is that operand with its quiet bit set and `out_inv_snan` is 1. The left operand is chosen when both operands are signaling NaNs.
- R3: When neither operand is a signaling NaN but one of them is a quiet NaN, that operand is returned bit for bit with both flags 0. The left operand is checked first. A signaling NaN on the right still takes priority over a quiet NaN on the left.
- R4: Two infinities of the same sign produce the default quiet NaN, with `out_inv_inf` set to 1. The default quiet NaN is 32'h7FC00000 in single precision and 64'h7FF8000000000000 in double precision.
- R5: In every other case with an infinite operand, max returns +inf if either operand is +inf and otherwise the other operand. Min returns -inf if either operand is -inf and otherwise the other operand.
- R6: For finite operands of opposite sign, max returns the positive one and min returns the negative one. This includes +0 (all zero) against -0 (sign bit only).
- R7: For finite operands of the same sign, the operand with the larger unsigned {exponent, fraction} field has the larger magnitude. This ordering covers denormals and zeros. Max returns the larger value and min the smaller.
- R8: In single precision (`in_prec_dbl` = 0) the operands are taken from bits 31:0 and bits 63:32 of the inputs are ignored. Bits 63:32 of the result are 0. In double precision all 64 bits take part.
- R9: Each accepted beat produces exactly one result with its own flags. A flag is 1 only when its condition applies to that beat, and the two flags are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand beat present |
| in_ready | output | 1 | Block can accept a beat this cycle |
| in_lhs | input | 64 | Left operand (single precision in bits 31:0) |
| in_rhs | input | 64 | Right operand (single precision in bits 31:0) |
| in_op_min | input | 1 | 0 selects maximum, 1 selects minimum |
| in_prec_dbl | input | 1 | 0 selects single precision, 1 selects double precision |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | 64 | Selected or generated result |
| out_inv_snan | output | 1 | Invalid: a signaling NaN was an operand |
| out_inv_inf | output | 1 | Invalid: both operands were same-sign infinities |

## Verification
The block's only internal state is the output holding register. If that register were loaded or cleared at the wrong time, the fault would show up the next cycle. A lost beat would leave `out_valid` low. A dropped beat would show as `out_res` changing while `out_ready` is held low. A beat sent twice would show as `in_ready` rising while the output is still full. A fault in the priority chain or the ordering logic is purely combinational. It appears one cycle after acceptance as a wrong `out_res` or a wrong flag for that beat. The vectors therefore place each priority level against the level below it, and they cover both precisions with distinct upper halves.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int FP_W     = 64;
  localparam int SP_W     = 32;
  localparam int SP_EXP   = 8;
  localparam int SP_FRAC  = 23;
  localparam int DP_EXP   = 11;
  localparam int DP_FRAC  = 52;
  localparam int MAG_W    = FP_W - 1;

  localparam logic [FP_W-1:0] SP_QMASK = FP_W'(1) << (SP_FRAC - 1);
  localparam logic [FP_W-1:0] DP_QMASK = FP_W'(1) << (DP_FRAC - 1);
  localparam logic [FP_W-1:0] SP_DNAN  =
    (((FP_W'(1) << SP_EXP) - 1) << SP_FRAC) | SP_QMASK;
  localparam logic [FP_W-1:0] DP_DNAN  =
    (((FP_W'(1) << DP_EXP) - 1) << DP_FRAC) | DP_QMASK;

  typedef struct packed {
    logic             sign;
    logic             is_inf;
    logic             is_qnan;
    logic             is_snan;
    logic [MAG_W-1:0] mag;
    logic [FP_W-1:0]  plain;
    logic [FP_W-1:0]  quiet;
  } opnd_t;

  typedef enum logic [2:0] {
    PK_LEFT, PK_RIGHT, PK_QLEFT, PK_QRIGHT, PK_DNAN
  } pick_e;
endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
(
  input  logic [FP_W-1:0] word,
  input  logic            dbl,
  output opnd_t           info
);
  logic [SP_EXP-1:0]  s_exp;
  logic [SP_FRAC-1:0] s_frac;
  logic [DP_EXP-1:0]  d_exp;
  logic [DP_FRAC-1:0] d_frac;
  logic exp_ones, frac_nz, qbit;

  assign s_exp  = word[SP_W-2 -: SP_EXP];
  assign s_frac = word[SP_FRAC-1:0];
  assign d_exp  = word[FP_W-2 -: DP_EXP];
  assign d_frac = word[DP_FRAC-1:0];

  always_comb begin
    if (dbl) begin
      exp_ones   = &d_exp;
      frac_nz    = |d_frac;
      qbit       = d_frac[DP_FRAC-1];
      info.sign  = word[FP_W-1];
      info.mag   = word[FP_W-2:0];
      info.plain = word;
      info.quiet = word | DP_QMASK;
    end else begin
      exp_ones   = &s_exp;
      frac_nz    = |s_frac;
      qbit       = s_frac[SP_FRAC-1];
      info.sign  = word[SP_W-1];
      info.mag   = MAG_W'(word[SP_W-2:0]);
      info.plain = FP_W'(word[SP_W-1:0]);
      info.quiet = FP_W'(word[SP_W-1:0]) | SP_QMASK;
    end
    info.is_inf  = exp_ones && !frac_nz;
    info.is_qnan = exp_ones && frac_nz && qbit;
    info.is_snan = exp_ones && frac_nz && !qbit;
  end
endmodule

// File: rtl/fpmm_pick.sv
module fpmm_pick
  import fpmm_pkg::*;
(
  input  opnd_t           lhs,
  input  opnd_t           rhs,
  input  logic            op_min,
  input  logic            dbl,
  output logic [FP_W-1:0] res,
  output logic            f_snan,
  output logic            f_inf
);
  pick_e sel;
  logic  lgt;

  assign lgt = lhs.mag > rhs.mag;

  always_comb begin
    f_snan = 1'b0;
    f_inf  = 1'b0;
    if (lhs.is_snan) begin
      sel = PK_QLEFT;  f_snan = 1'b1;
    end else if (rhs.is_snan) begin
      sel = PK_QRIGHT; f_snan = 1'b1;
    end else if (lhs.is_qnan) begin
      sel = PK_LEFT;
    end else if (rhs.is_qnan) begin
      sel = PK_RIGHT;
    end else if (lhs.is_inf) begin
      if (rhs.is_inf && (lhs.sign == rhs.sign)) begin
        sel = PK_DNAN; f_inf = 1'b1;
      end else begin
        sel = (lhs.sign == op_min) ? PK_LEFT : PK_RIGHT;
      end
    end else if (rhs.is_inf) begin
      sel = (rhs.sign != op_min) ? PK_LEFT : PK_RIGHT;
    end else if (lhs.sign != rhs.sign) begin
      sel = (lhs.sign == op_min) ? PK_LEFT : PK_RIGHT;
    end else begin
      sel = (lgt ^ lhs.sign ^ op_min) ? PK_LEFT : PK_RIGHT;
    end
  end

  always_comb begin
    unique case (sel)
      PK_LEFT:   res = lhs.plain;
      PK_RIGHT:  res = rhs.plain;
      PK_QLEFT:  res = lhs.quiet;
      PK_QRIGHT: res = rhs.quiet;
      default:   res = dbl ? DP_DNAN : SP_DNAN;
    endcase
  end
endmodule

// File: rtl/fpmm_stage.sv
module fpmm_stage #(
  parameter int W = 66
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      q     <= '0;
    end else if (load) begin
      valid <= 1'b1;
      q     <= d;
    end else if (drain) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_minmax.sv
module fp_minmax
  import fpmm_pkg::*;
#(
  parameter bit ALLOW_DOUBLE = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [FP_W-1:0] in_lhs,
  input  logic [FP_W-1:0] in_rhs,
  input  logic            in_op_min,
  input  logic            in_prec_dbl,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [FP_W-1:0] out_res,
  output logic            out_inv_snan,
  output logic            out_inv_inf
);
  localparam int ST_W = FP_W + 2;

  logic            dbl;
  logic [FP_W-1:0] words [2];
  opnd_t           info  [2];
  logic [FP_W-1:0] res;
  logic            f_snan, f_inf;
  logic [ST_W-1:0] st_q;
  logic            accept;

  generate
    if (ALLOW_DOUBLE) begin : g_dbl
      assign dbl = in_prec_dbl;
    end else begin : g_sgl
      assign dbl = 1'b0;
    end
  endgenerate

  assign words[0] = in_lhs;
  assign words[1] = in_rhs;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpmm_classify u_cls (
      .word (words[i]),
      .dbl  (dbl),
      .info (info[i])
    );
  end

  fpmm_pick u_pick (
    .lhs    (info[0]),
    .rhs    (info[1]),
    .op_min (in_op_min),
    .dbl    (dbl),
    .res    (res),
    .f_snan (f_snan),
    .f_inf  (f_inf)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fpmm_stage #(.W(ST_W)) u_stage (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .drain (out_ready),
    .d     ({f_inf, f_snan, res}),
    .valid (out_valid),
    .q     (st_q)
  );

  assign out_res      = st_q[FP_W-1:0];
  assign out_inv_snan = st_q[FP_W];
  assign out_inv_inf  = st_q[FP_W+1];
endmodule

// File: rtl/fp_minmax_chk.sv
module fp_minmax_chk
  import fpmm_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            in_prec_dbl,
  input logic            out_valid,
  input logic            out_ready,
  input logic [FP_W-1:0] out_res,
  input logic            out_inv_snan,
  input logic            out_inv_inf
);
  logic cap_dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_dbl <= 1'b0;
    else if (in_valid && in_ready) cap_dbl <= in_prec_dbl;
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)
      && $stable(out_inv_snan) && $stable(out_inv_inf)));

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv_snan) |->
      (cap_dbl ? out_res[DP_FRAC-1] : out_res[SP_FRAC-1]));

  p_dnan_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_inv_inf) |->
      (out_res == (cap_dbl ? DP_DNAN : SP_DNAN)));

  p_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cap_dbl) |-> (out_res[FP_W-1:SP_W] == '0));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_inv_snan && out_inv_inf));
endmodule

bind fp_minmax fp_minmax_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_prec_dbl  (in_prec_dbl),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_res      (out_res),
  .out_inv_snan (out_inv_snan),
  .out_inv_inf  (out_inv_inf)
);

// File: tb/tb_fp_minmax.sv
module tb_fp_minmax;
  localparam int NV = 25;
  // entry: {op_min, dbl, lhs, rhs, exp_res, exp_snan, exp_inf}
  localparam logic [195:0] VEC [NV] = '{
    {1'b0,1'b0,64'h3F800000,64'h40000000,64'h40000000,1'b0,1'b0}, // R7
    {1'b1,1'b0,64'h3F800000,64'h40000000,64'h3F800000,1'b0,1'b0}, // R7
    {1'b0,1'b0,64'hBF800000,64'hC0000000,64'hBF800000,1'b0,1'b0}, // R7
    {1'b1,1'b0,64'hBF800000,64'hC0000000,64'hC0000000,1'b0,1'b0}, // R7
    {1'b0,1'b0,64'h00000001,64'h00800000,64'h00800000,1'b0,1'b0}, // R7
    {1'b0,1'b0,64'h00000000,64'h80000000,64'h00000000,1'b0,1'b0}, // R6
    {1'b1,1'b0,64'h00000000,64'h80000000,64'h80000000,1'b0,1'b0}, // R6
    {1'b0,1'b0,64'hBF800000,64'h40000000,64'h40000000,1'b0,1'b0}, // R6
    {1'b0,1'b0,64'h7F800001,64'h7FC00001,64'h7FC00001,1'b1,1'b0}, // R2
    {1'b1,1'b0,64'h7F800001,64'hFF800005,64'h7FC00001,1'b1,1'b0}, // R2
    {1'b0,1'b0,64'h7FC00001,64'hFF800005,64'hFFC00005,1'b1,1'b0}, // R3
    {1'b0,1'b0,64'h7FC00002,64'hFFC00003,64'h7FC00002,1'b0,1'b0}, // R3
    {1'b1,1'b0,64'h3F800000,64'hFFC00003,64'hFFC00003,1'b0,1'b0}, // R3
    {1'b0,1'b0,64'h7F800000,64'h7F800000,64'h7FC00000,1'b0,1'b1}, // R4
    {1'b1,1'b0,64'hFF800000,64'hFF800000,64'h7FC00000,1'b0,1'b1}, // R4
    {1'b0,1'b0,64'hFF800000,64'h3F800000,64'h3F800000,1'b0,1'b0}, // R5
    {1'b1,1'b0,64'h3F800000,64'hFF800000,64'hFF800000,1'b0,1'b0}, // R5
    {1'b0,1'b0,64'h7F800000,64'hFF800000,64'h7F800000,1'b0,1'b0}, // R5
    {1'b1,1'b0,64'h7F800000,64'hFF800000,64'hFF800000,1'b0,1'b0}, // R5
    {1'b0,1'b0,64'hDEADBEEF3F800000,64'h1234567840000000,64'h40000000,1'b0,1'b0}, // R8
    {1'b0,1'b1,64'h3FF0000000000001,64'h3FF0000000000000,64'h3FF0000000000001,1'b0,1'b0}, // R8
    {1'b1,1'b1,64'hC008000000000000,64'h4000000000000000,64'hC008000000000000,1'b0,1'b0}, // R6
    {1'b0,1'b1,64'h7FF0000000000001,64'h3FF0000000000000,64'h7FF8000000000001,1'b1,1'b0}, // R2
    {1'b0,1'b1,64'h7FF0000000000000,64'h7FF0000000000000,64'h7FF8000000000000,1'b0,1'b1}, // R4
    {1'b1,1'b1,64'h3FF0000000000000,64'h7FF0000000000000,64'h3FF0000000000000,1'b0,1'b0}  // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_lhs = '0;
  logic [63:0] in_rhs = '0;
  logic        in_op_min = 1'b0;
  logic        in_prec_dbl = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_res;
  logic        out_inv_snan;
  logic        out_inv_inf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  fp_minmax dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_lhs(in_lhs), .in_rhs(in_rhs), .in_op_min(in_op_min),
    .in_prec_dbl(in_prec_dbl), .out_valid(out_valid), .out_ready(out_ready),
    .out_res(out_res), .out_inv_snan(out_inv_snan), .out_inv_inf(out_inv_inf)
  );

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 2, 3, 4:        return "R7";
      5, 6, 7, 21:          return "R6";
      8, 9, 22:             return "R2";
      10, 11, 12:           return "R3";
      13, 14, 23:           return "R4";
      19, 20:               return "R8";
      default:              return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [65:0] act,
                       input logic [65:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // one beat, result sampled at the falling edge after the accepting edge
  task automatic beat(input logic op, input logic dbl,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic [65:0] exp, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op_min = op; in_prec_dbl = dbl;
    in_lhs = a; in_rhs = b; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, 65'h0}, {1'b1, 65'h0});
    check(tag, {out_inv_inf, out_inv_snan, out_res}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {64'h0, out_valid, in_ready}, {64'h0, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {64'h0, out_valid, in_ready}, {64'h0, 1'b0, 1'b1});

    for (int i = 0; i < NV; i++) begin
      beat(VEC[i][195], VEC[i][194], VEC[i][193:130], VEC[i][129:66],
           {VEC[i][0], VEC[i][1], VEC[i][65:2]}, vec_tag(i));
    end

    // R1 back-pressure: hold result, block input, then drain
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op_min = 1'b0; in_prec_dbl = 1'b0;
    in_lhs = 64'h3F800000; in_rhs = 64'h40000000;
    @(posedge clk);
    @(negedge clk);
    in_lhs = 64'h7F800000; in_rhs = 64'h7F800000;
    check("R1", {64'h0, out_valid, in_ready}, {64'h0, 1'b1, 1'b0});
    repeat (3) @(negedge clk);
    check("R1", {out_inv_inf, out_inv_snan, out_res}, {2'b00, 64'h40000000});
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    // the waiting beat was accepted on the draining edge: R9 flags now its own
    check("R9", {out_valid, out_inv_inf, out_inv_snan, out_res},
          {1'b1, 2'b10, 64'h7FC00000});
    @(posedge clk);
    @(negedge clk);
    check("R1", {64'h0, out_valid, in_ready}, {64'h0, 1'b0, 1'b1});

    // R9 flags clear on a clean beat right after an exception beat
    beat(1'b0, 1'b1, 64'h7FF0000000000001, 64'h0, {2'b01, 64'h7FF8000000000001}, "R9");
    beat(1'b0, 1'b1, 64'h4000000000000000, 64'h0, {2'b00, 64'h4000000000000000}, "R9");

    // R8 upper half ignored on a quiet NaN in single precision
    beat(1'b1, 1'b0, 64'hFFFFFFFF7FC00009, 64'hAAAAAAAA3F800000,
         {2'b00, 64'h7FC00009}, "R8");
    summary();
  end
endmodule